// File: doc/BRIEF.md
# Data Watchpoint Comparator

This block watches the load/store traffic of a 32-bit processor on behalf of its debug unit. It has two independent watchpoint channels. Each channel compares the address of every valid access against a programmed address. When the comparator is in exact mode, a channel can drop any number of low address bits from that compare, from none up to 31. The watched location then grows into an aligned power-of-two window of 2 bytes to 2 GB, and the second channel stays free.

A channel can also require a data-value condition before it reports a hit. That condition is either "access data equals the programmed value" or "access data differs from it". Separate read and write enables decide whether a channel reacts to loads, stores or both. A small write-only register port programs everything. Each channel reports a hit as a pulse on `hit_o`, registered on the access strobe.

Top module: `dwp_top`

## Requirements
- R1: After reset every control field, compare address and compare value is zero, and `hit_o` is 0. With reset values, no access produces a hit, even one at address 0.
- R2: `hit_o[c]` is 1 in the cycle right after an access with `acc_vld`=1 that matches channel c, and only then. Consecutive matching strobes give consecutive hit cycles, and an idle cycle gives 0.
- R3: A read access (`acc_wr`=0) can hit channel c only if its read enable is set. A write access (`acc_wr`=1) can hit only if its write enable is set.
- R4: With a mask count of 0, the access address must equal the programmed address on all 32 bits.
- R5: With a mask count n from 1 to 31, address bits n-1..0 are left out of the compare. The count is the 5-bit value {high bit, low nibble}.
- R6: The mask count only applies when the compare mode field (`cfg_wdata[1:0]` of register 0) is 00. For modes 01, 10 and 11, the full 32-bit compare is used whatever the count.
- R7: With the value qualifier disabled, the access data has no effect on the hit.
- R8: With the value qualifier enabled, polarity 0 requires access data equal to the programmed value, and polarity 1 requires it to differ.
- R9: The two channels are independent. The fields of one channel never change the hits of the other.
- R10: Register map. `cfg_sel`=0 is the control word: bits [1:0] hold the mode. Byte 1+c holds channel c's fields: bit 0 read enable, bit 1 write enable, bit 2 value enable, bit 3 polarity, bits 7:4 mask low nibble. Bit 24+c holds the channel's mask high bit. `cfg_sel`=1+c holds the address of channel c, and `cfg_sel`=3+c holds its value. A write takes effect for accesses in the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| acc_vld | input | 1 | Valid access strobe |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access address |
| acc_data | input | 32 | Access data |
| hit_o | output | 2 | Per-channel registered hit |

## Verification
The bench builds the block with its default 32-bit address and data widths. At these widths every one of the 32 mask counts can be paired with a one-bit address flip at every one of the 32 positions, on both channels at once, with the two channels given mirrored counts. This exposes an off-by-one at either end of the mask. Each non-exact mode, both directions, and all four value-qualifier settings are also swept against an arithmetic shift-based model.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  localparam int NCH    = 2;
  localparam int MCNT_W = 5;
  localparam int REG_W  = 32;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    CMP_EXACT = 2'b00,
    CMP_PAIR1 = 2'b01,
    CMP_PAIR2 = 2'b10,
    CMP_PAIR3 = 2'b11
  } cmp_mode_e;

  typedef struct packed {
    logic              rd_en;
    logic              wr_en;
    logic              dv_en;
    logic              dv_inv;
    logic [MCNT_W-1:0] mcnt;
  } ch_cfg_t;
endpackage

// File: rtl/dwp_regs.sv
module dwp_regs
  import dwp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [SEL_W-1:0]        sel,
  input  logic [REG_W-1:0]        wdata,
  output cmp_mode_e               mode,
  output ch_cfg_t                 cfg   [NCH],
  output logic [ADDR_W-1:0]       caddr [NCH],
  output logic [DATA_W-1:0]       cval  [NCH]
);
  localparam int CH_BYTE  = 8;
  localparam int HI_BASE  = 24;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= CMP_EXACT;
      for (int c = 0; c < NCH; c++) begin
        cfg[c]   <= '0;
        caddr[c] <= '0;
        cval[c]  <= '0;
      end
    end else if (we) begin
      if (sel == '0) begin
        mode <= cmp_mode_e'(wdata[1:0]);
        for (int c = 0; c < NCH; c++) begin
          cfg[c].rd_en  <= wdata[CH_BYTE*(c+1)];
          cfg[c].wr_en  <= wdata[CH_BYTE*(c+1)+1];
          cfg[c].dv_en  <= wdata[CH_BYTE*(c+1)+2];
          cfg[c].dv_inv <= wdata[CH_BYTE*(c+1)+3];
          cfg[c].mcnt   <= {wdata[HI_BASE+c], wdata[CH_BYTE*(c+1)+4 +: 4]};
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (sel == SEL_W'(1 + c))       caddr[c] <= wdata[ADDR_W-1:0];
        if (sel == SEL_W'(1 + NCH + c)) cval[c]  <= wdata[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dwp_chan.sv
module dwp_chan
  import dwp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmp_mode_e         mode,
  input  ch_cfg_t           cfg,
  input  logic [ADDR_W-1:0] caddr,
  input  logic [DATA_W-1:0] cval,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  output logic              hit_q
);
  // Mask with the n lowest bits cleared; counts >= ADDR_W clear everything.
  function automatic logic [ADDR_W-1:0] low_clear_mask(input logic [MCNT_W-1:0] n);
    logic [ADDR_W-1:0] ones;
    ones = '1;
    return ones << n;
  endfunction

  function automatic logic value_ok(input logic en, input logic inv,
                                    input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b);
    return !en || ((a != b) == inv);
  endfunction

  logic [ADDR_W-1:0] eff_mask;
  logic              addr_match;
  logic              val_match;
  logic              dir_ok;
  logic              fire;

  assign eff_mask   = (mode == CMP_EXACT) ? low_clear_mask(cfg.mcnt) : '1;
  assign addr_match = ((acc_addr & eff_mask) == (caddr & eff_mask));
  assign val_match  = value_ok(cfg.dv_en, cfg.dv_inv, acc_data, cval);
  assign dir_ok     = acc_wr ? cfg.wr_en : cfg.rd_en;
  assign fire       = acc_vld && dir_ok && addr_match && val_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= fire;
  end

  a_r2_hit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(acc_vld));

  a_r3_direction_gate: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(acc_wr ? cfg.wr_en : cfg.rd_en));

  a_r4_full_compare_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(cfg.mcnt == '0)) |-> $past(acc_addr == caddr));

  a_r6_nonexact_full_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(mode != CMP_EXACT)) |-> $past(acc_addr == caddr));

  a_r7_address_required: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(addr_match));

  a_r8_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(cfg.dv_en)) |-> $past((acc_data == cval) != cfg.dv_inv));
endmodule

// File: rtl/dwp_top.sv
module dwp_top
  import dwp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  output logic [NCH-1:0]    hit_o
);
  cmp_mode_e         mode;
  ch_cfg_t           cfg   [NCH];
  logic [ADDR_W-1:0] caddr [NCH];
  logic [DATA_W-1:0] cval  [NCH];

  dwp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .mode  (mode),
    .cfg   (cfg),
    .caddr (caddr),
    .cval  (cval)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dwp_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .cfg      (cfg[c]),
      .caddr    (caddr[c]),
      .cval     (cval[c]),
      .acc_vld  (acc_vld),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr),
      .acc_data (acc_data),
      .hit_q    (hit_o[c])
    );
  end

  a_r1_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!acc_vld) |-> (hit_o == '0));
endmodule

// File: tb/dwp_top_tb.sv
module dwp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_vld = 1'b0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [31:0] acc_data = '0;
  logic [1:0]  hit_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench copy of programmed state
  int          m_mode;
  bit          m_re[2], m_we[2], m_dve[2], m_inv[2];
  int          m_cnt[2];
  logic [31:0] m_addr[2], m_val[2];
  logic [1:0]  pending = '0;
  string       pend_tag = "R1";

  always #10 clk = ~clk;

  dwp_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_data(acc_data), .hit_o(hit_o)
  );

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: hit_o actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic bit model(int c, bit wr, logic [31:0] a, logic [31:0] d);
    bit dir, am, vm;
    int sh;
    dir = wr ? m_we[c] : m_re[c];
    sh  = (m_mode == 0) ? m_cnt[c] : 0;
    am  = ((a >> sh) == (m_addr[c] >> sh));
    vm  = m_dve[c] ? ((d == m_val[c]) ^ m_inv[c]) : 1'b1;
    return dir && am && vm;
  endfunction

  // one clock: check the hit owed by the previous cycle, then drive this one
  task automatic cycle(string tag, bit vld, bit wr, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    check(pend_tag, hit_o, pending);
    cfg_we = 1'b0;
    acc_vld = vld; acc_wr = wr; acc_addr = a; acc_data = d;
    pending = vld ? {model(1, wr, a, d), model(0, wr, a, d)} : 2'b00;
    pend_tag = tag;
  endtask

  task automatic wreg(logic [2:0] s, logic [31:0] v);
    @(negedge clk);
    check(pend_tag, hit_o, pending);
    pending = '0;
    acc_vld = 1'b0;
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    if (s == 1 || s == 2) m_addr[s-1] = v;
    if (s == 3 || s == 4) m_val[s-3] = v;
  endtask

  // R10 control word composer
  task automatic wctl(int mode, bit re0, bit we0, bit dv0, bit iv0, int c0,
                      bit re1, bit we1, bit dv1, bit iv1, int c1);
    logic [31:0] w;
    w = '0;
    w[1:0] = 2'(mode);
    w[15:8]  = {4'(c0), iv0, dv0, we0, re0};
    w[23:16] = {4'(c1), iv1, dv1, we1, re1};
    w[24] = c0[4];
    w[25] = c1[4];
    m_mode = mode;
    m_re[0] = re0; m_we[0] = we0; m_dve[0] = dv0; m_inv[0] = iv0; m_cnt[0] = c0;
    m_re[1] = re1; m_we[1] = we1; m_dve[1] = dv1; m_inv[1] = iv1; m_cnt[1] = c1;
    wreg(3'd0, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2: watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_re[c] = 0; m_we[c] = 0; m_dve[c] = 0; m_inv[c] = 0; m_cnt[c] = 0;
      m_addr[c] = '0; m_val[c] = '0;
    end
    m_mode = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", hit_o, 2'b00);
    rst_n = 1'b1;
    // R1: reset contents give no hit even at address 0
    cycle("R1", 1, 0, 32'h0, 32'h0);
    cycle("R1", 1, 1, 32'h0, 32'h0);

    // R4/R5/R9: every count against every single-bit flip, mirrored counts
    wreg(3'd1, 32'hA5C3_3C5A);
    wreg(3'd2, 32'hA5C3_3C5A);
    for (int n = 0; n < 32; n++) begin
      wctl(0, 1, 1, 0, 0, n, 1, 1, 0, 0, 31 - n);
      cycle(n == 0 ? "R4" : "R5", 1, n[0], 32'hA5C3_3C5A, 32'h0);
      for (int k = 0; k < 32; k++)
        cycle(n == 0 ? "R4 flip" : "R5 R9 flip", 1, k[0], 32'hA5C3_3C5A ^ (32'h1 << k), 32'h0);
    end

    // R6: non-exact modes ignore the count
    for (int md = 1; md < 4; md++) begin
      wctl(md, 1, 1, 0, 0, 8, 1, 1, 0, 0, 31);
      cycle("R6 exact addr", 1, 0, 32'hA5C3_3C5A, 32'h0);
      cycle("R6 low flip", 1, 0, 32'hA5C3_3C5B, 32'h0);
      cycle("R6 bit30 flip", 1, 1, 32'hE5C3_3C5A, 32'h0);
    end

    // R3: direction gating; R2: back-to-back strobes and idle
    wctl(0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    cycle("R3 read", 1, 0, 32'hA5C3_3C5A, 32'h0);
    cycle("R3 write", 1, 1, 32'hA5C3_3C5A, 32'h0);
    cycle("R2 burst", 1, 0, 32'hA5C3_3C5A, 32'h0);
    cycle("R2 idle", 0, 0, 32'hA5C3_3C5A, 32'h0);
    cycle("R2 idle", 0, 1, 32'hA5C3_3C5A, 32'h0);

    // R7/R8: value qualifier, all enable/polarity settings
    wreg(3'd3, 32'h1234_5678);
    wreg(3'd4, 32'h1234_5678);
    for (int q = 0; q < 4; q++) begin
      wctl(0, 1, 1, q[0], q[1], 4, 1, 1, !q[0], q[1], 4);
      cycle("R7 R8 equal", 1, 0, 32'hA5C3_3C50, 32'h1234_5678);
      cycle("R7 R8 differ", 1, 1, 32'hA5C3_3C5F, 32'h1234_5679);
      cycle("R7 R8 differ hi", 1, 0, 32'hA5C3_3C5A, 32'h9234_5678);
    end

    // R10: address register per channel, distinct values
    wreg(3'd2, 32'h0000_1000);
    wctl(0, 1, 1, 0, 0, 0, 1, 1, 0, 0, 12);
    cycle("R10 ch1 addr", 1, 0, 32'h0000_1FFF, 32'h0);
    cycle("R10 ch0 addr", 1, 0, 32'hA5C3_3C5A, 32'h0);
    cycle("R10 drain", 0, 0, 32'h0, 32'h0);
    @(negedge clk);
    check(pend_tag, hit_o, pending);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule